// File: doc/BRIEF.md
# Multi-Mode Reload Timer Channel

A 16-bit timer channel that runs in one of three functions, chosen by a 2-bit mode input. In timer mode it counts down on one of four prescaled clock enables. In event mode it counts down on edges of an external pin, or on overflow pulses from a neighbouring channel. In measurement mode it counts up on a prescaled enable and, on a qualifying pin edge, copies the count into a capture register and clears itself. This measures either the period or the width of the pin signal.

The clock-select input does two jobs. In timer and measurement modes it picks a prescaler tap. In event mode its upper bit picks between the pin and the cascade input. Software reaches the 16-bit value through a byte-wide bus, one lane at a time. The overflow output is a one-cycle pulse, and it also serves as the cascade source for the next channel in a ring.

Top module: `mrt_channel`

## Requirements
- R1: After a synchronous reset, the reload value, counter and capture register are all zero, and ovf_o and irq_o are low.
- R2: A write with bus_addr_i=0 sets reload bits 7:0, and a write with bus_addr_i=1 sets bits 15:8. While start_i is low, the counter also takes the new reload value. While start_i is high, a write changes only the reload value. A read returns the low byte for address 0 and the high byte for address 1.
- R3: In timer mode (mode_i=00), the counter decrements by one on each cycle where the selected tick is high. clk_sel_i 00, 01, 10 and 11 select tick_i bits 0, 1, 2 and 3, and the unselected bits have no effect.
- R4: In timer or event mode, a count enable that arrives while the counter is zero reloads it from the reload value. ovf_o is then high for exactly the following cycle.
- R5: While start_i is low and no write occurs, the counter holds its value whatever the ticks, pin or cascade inputs do.
- R6: In event mode (mode_i=01) with clk_sel_i[1]=0, the counter decrements on pin edges chosen by edge_sel_i: 00 falling, 01 rising, 10 or 11 both. With clk_sel_i[1]=1, it decrements once per cycle where cascade_i is high, and pin edges are ignored.
- R7: In measurement mode (mode_i=10), the counter increments on the selected tick. A qualifying pin edge copies the count to the capture register, clears the counter and pulses irq_o for one cycle. edge_sel_i 00 or 01 gives period measurement (falling or rising edge), and 10 or 11 gives width measurement (both edges).
- R8: In measurement mode, bus reads return the capture register. In the other modes they return the live counter.
- R9: mode_i=11 behaves exactly as timer mode.
- R10: In measurement mode, a tick at count 0xFFFF wraps the counter to zero and pulses ovf_o without pulsing irq_o.
- R11: In timer and event modes, irq_o pulses together with ovf_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Function select |
| clk_sel_i | input | 2 | Tick tap, or event source in event mode |
| edge_sel_i | input | 2 | Pin edge qualification |
| start_i | input | 1 | Count enable |
| tick_i | input | 4 | Prescaled clock enables (divide 1/2, 8, 32, slow clock) |
| pin_i | input | 1 | Asynchronous external input |
| cascade_i | input | 1 | Overflow pulse from neighbour channel |
| bus_wr_i | input | 1 | Byte write strobe |
| bus_addr_i | input | 1 | Byte lane select |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for selected lane |
| ovf_o | output | 1 | Overflow/underflow pulse, also the cascade output |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The bench steers one tick bit at a time against each clock-select value. A tap mux that is wired wrong then decrements on the wrong source or never moves. Underflow is driven through zero to confirm the reload and a single-cycle pulse. A design that skipped the reload, or counted the zero state twice, would report the wrong value or a stretched pulse. Measurement runs period and width captures back to back and reads the capture after further ticks: a read of the live counter, or a capture that does not clear the counter, gives a different value. A test forces the 0xFFFF wrap, and the running-write test catches a counter that a bus write disturbs while it is counting.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

    typedef enum logic [1:0] {
        MODE_TIMER   = 2'b00,
        MODE_EVENT   = 2'b01,
        MODE_MEASURE = 2'b10,
        MODE_RSVD    = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        EDGE_FALL     = 2'b00,
        EDGE_RISE     = 2'b01,
        EDGE_BOTH     = 2'b10,
        EDGE_BOTH_ALT = 2'b11
    } edge_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edges_t;

    typedef struct packed {
        logic cnt_en;
        logic meas_edge;
    } ctl_t;

    // Reserved encoding falls back to timer behaviour (R9)
    function automatic mode_e resolve_mode(input logic [1:0] m);
        return (m == 2'b11) ? MODE_TIMER : mode_e'(m);
    endfunction

    function automatic logic qual_edge(input edge_e s, input logic r, input logic f);
        case (s)
            EDGE_FALL: return f;
            EDGE_RISE: return r;
            default:   return r | f;
        endcase
    endfunction

endpackage

// File: rtl/mrt_edge_qual.sv
module mrt_edge_qual
    import mrt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pin_i,
    output edges_t edges_o
);
    logic [SYNC_STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[SYNC_STAGES-1:0], pin_i};
    end

    always_comb begin
        edges_o.rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
        edges_o.fall = ~sh_q[SYNC_STAGES-1] & sh_q[SYNC_STAGES];
    end

    // Rise and fall cannot occur together (R6)
    AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(edges_o.rise && edges_o.fall)); // R6

endmodule

// File: rtl/mrt_src_sel.sv
module mrt_src_sel
    import mrt_pkg::*;
#(
    parameter int NUM_TAPS = 4,
    parameter int SEL_W    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  mode_e               mode_i,
    input  logic [SEL_W-1:0]    clk_sel_i,
    input  edge_e               esel_i,
    input  logic [NUM_TAPS-1:0] tick_i,
    input  edges_t              edges_i,
    input  logic                cascade_i,
    output ctl_t                ctl_o
);
    logic tap_hit;
    logic pin_evt;

    always_comb begin
        tap_hit = tick_i[clk_sel_i];
        pin_evt = qual_edge(esel_i, edges_i.rise, edges_i.fall);
        ctl_o   = '0;
        case (mode_i)
            MODE_EVENT: begin
                ctl_o.cnt_en = clk_sel_i[SEL_W-1] ? cascade_i : pin_evt;
            end
            MODE_MEASURE: begin
                ctl_o.cnt_en    = tap_hit;
                ctl_o.meas_edge = pin_evt;
            end
            default: begin
                ctl_o.cnt_en = tap_hit;
            end
        endcase
    end

    // Capture edges exist only in measurement mode (R7)
    AST_NO_STRAY_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (mode_i != MODE_MEASURE) |-> !ctl_o.meas_edge); // R7

endmodule

// File: rtl/mrt_counter.sv
module mrt_counter
    import mrt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BUS_W  = 8,
    parameter int LANE_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_e             mode_i,
    input  logic              start_i,
    input  ctl_t              ctl_i,
    input  logic              wr_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  cap_o,
    output logic              ovf_o,
    output logic              irq_o
);
    localparam int LANES = CNT_W / BUS_W;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q, cap_q, reload_q, reload_nxt;
    logic ovf_q, irq_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign reload_nxt[l*BUS_W +: BUS_W] =
            (wr_i && lane_i == LANE_W'(l)) ? wdata_i : reload_q[l*BUS_W +: BUS_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            cap_q    <= '0;
            reload_q <= '0;
            ovf_q    <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            reload_q <= reload_nxt;
            ovf_q    <= 1'b0;
            irq_q    <= 1'b0;
            if (!start_i) begin
                if (wr_i) cnt_q <= reload_nxt;
            end else if (mode_i == MODE_MEASURE) begin
                if (ctl_i.meas_edge) begin
                    cap_q <= cnt_q;
                    cnt_q <= '0;
                    irq_q <= 1'b1;
                end else if (ctl_i.cnt_en) begin
                    cnt_q <= cnt_q + ONE;
                    if (cnt_q == '1) ovf_q <= 1'b1;
                end
            end else if (ctl_i.cnt_en) begin
                if (cnt_q == '0) begin
                    cnt_q <= reload_q;
                    ovf_q <= 1'b1;
                    irq_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - ONE;
                end
            end
        end
    end

    assign cnt_o = cnt_q;
    assign cap_o = cap_q;
    assign ovf_o = ovf_q;
    assign irq_o = irq_q;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (cnt_q == '0 && cap_q == '0 && reload_q == '0 && !ovf_q && !irq_q)); // R1

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !wr_i) |=> $stable(cnt_q)); // R5

    AST_DEC_ONE: assert property (@(posedge clk) disable iff (rst)
        (start_i && mode_i != MODE_MEASURE && ctl_i.cnt_en && cnt_q != '0)
        |=> (cnt_q == $past(cnt_q) - ONE && !ovf_q)); // R3

    AST_UNDERFLOW_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (start_i && mode_i != MODE_MEASURE && ctl_i.cnt_en && cnt_q == '0)
        |=> (cnt_q == $past(reload_q) && ovf_q && irq_q)); // R4

    AST_CAPTURE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (start_i && mode_i == MODE_MEASURE && ctl_i.meas_edge)
        |=> (cnt_q == '0 && cap_q == $past(cnt_q) && irq_q && !ovf_q)); // R7

    AST_MEAS_WRAP: assert property (@(posedge clk) disable iff (rst)
        (start_i && mode_i == MODE_MEASURE && !ctl_i.meas_edge && ctl_i.cnt_en && cnt_q == '1)
        |=> (cnt_q == '0 && ovf_q && !irq_q)); // R10

endmodule

// File: rtl/mrt_channel.sv
module mrt_channel
    import mrt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BUS_W       = 8,
    parameter int NUM_TAPS    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = $clog2(CNT_W / BUS_W),
    parameter int SEL_W       = $clog2(NUM_TAPS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          mode_i,
    input  logic [SEL_W-1:0]    clk_sel_i,
    input  logic [1:0]          edge_sel_i,
    input  logic                start_i,
    input  logic [NUM_TAPS-1:0] tick_i,
    input  logic                pin_i,
    input  logic                cascade_i,
    input  logic                bus_wr_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [BUS_W-1:0]    bus_wdata_i,
    output logic [BUS_W-1:0]    bus_rdata_o,
    output logic                ovf_o,
    output logic                irq_o
);
    localparam int LANES = CNT_W / BUS_W;

    mode_e            mode;   // mode 11 folded into timer (R9)
    edges_t           edges;
    ctl_t             ctl;
    logic [CNT_W-1:0] cnt, cap, rd_val;

    assign mode = resolve_mode(mode_i);

    mrt_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .pin_i   (pin_i),
        .edges_o (edges)
    );

    mrt_src_sel #(.NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode),
        .clk_sel_i (clk_sel_i),
        .esel_i    (edge_e'(edge_sel_i)),
        .tick_i    (tick_i),
        .edges_i   (edges),
        .cascade_i (cascade_i),
        .ctl_o     (ctl)
    );

    mrt_counter #(.CNT_W(CNT_W), .BUS_W(BUS_W), .LANE_W(ADDR_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .mode_i  (mode),
        .start_i (start_i),
        .ctl_i   (ctl),
        .wr_i    (bus_wr_i),
        .lane_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .cnt_o   (cnt),
        .cap_o   (cap),
        .ovf_o   (ovf_o),
        .irq_o   (irq_o)
    );

    // Read source: capture in measurement mode, live count otherwise (R8)
    assign rd_val = (mode == MODE_MEASURE) ? cap : cnt;

    always_comb begin
        bus_rdata_o = '0;
        for (int l = 0; l < LANES; l++) begin
            if (bus_addr_i == ADDR_W'(l)) bus_rdata_o = rd_val[l*BUS_W +: BUS_W];
        end
    end

    AST_IRQ_WITH_OVF: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !irq_o) |-> $past(mode == MODE_MEASURE)); // R11

endmodule

// File: tb/mrt_channel_test.sv
module mrt_channel_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode_i, clk_sel_i, edge_sel_i;
    logic       start_i;
    logic [3:0] tick_i;
    logic       pin_i, cascade_i;
    logic       bus_wr_i;
    logic [0:0] bus_addr_i;
    logic [7:0] bus_wdata_i, bus_rdata_o;
    logic       ovf_o, irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    mrt_channel uut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .clk_sel_i(clk_sel_i),
        .edge_sel_i(edge_sel_i), .start_i(start_i), .tick_i(tick_i),
        .pin_i(pin_i), .cascade_i(cascade_i), .bus_wr_i(bus_wr_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .ovf_o(ovf_o), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  cs;
        logic [3:0]  mask;
        logic [7:0]  n;
        logic [15:0] exp;
    } vec_t;

    // Each starts from 100 loaded while stopped
    localparam vec_t VECS [8] = '{
        '{2'b00, 2'b00, 4'b0001, 8'd5, 16'd95},   // R3 tap 0
        '{2'b00, 2'b01, 4'b0010, 8'd7, 16'd93},   // R3 tap 1
        '{2'b00, 2'b01, 4'b0001, 8'd7, 16'd100},  // R3 unselected tap ignored
        '{2'b00, 2'b10, 4'b0100, 8'd3, 16'd97},   // R3 tap 2
        '{2'b00, 2'b11, 4'b1000, 8'd4, 16'd96},   // R3 tap 3
        '{2'b11, 2'b00, 4'b0001, 8'd6, 16'd94},   // R9 reserved mode as timer
        '{2'b00, 2'b10, 4'b1111, 8'd2, 16'd98},   // R3 all ticks, one step each
        '{2'b01, 2'b10, 4'b0001, 8'd4, 16'd100}   // R6 cascade source ignores ticks
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic wr16(input logic [15:0] v);
        wr_byte(1'b0, v[7:0]);
        wr_byte(1'b1, v[15:8]);
    endtask

    task automatic rd16(output logic [15:0] v);
        bus_addr_i = 1'b0; #1; v[7:0]  = bus_rdata_o;
        bus_addr_i = 1'b1; #1; v[15:8] = bus_rdata_o;
    endtask

    task automatic pulse(input logic [3:0] mask, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = mask;
            @(negedge clk); tick_i = 4'b0;
        end
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk); pin_i = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        int irq_seen;
        rst = 1'b1; mode_i = 2'b00; clk_sel_i = 2'b00; edge_sel_i = 2'b00;
        start_i = 1'b0; tick_i = 4'b0; pin_i = 1'b0; cascade_i = 1'b0;
        bus_wr_i = 1'b0; bus_addr_i = 1'b0; bus_wdata_i = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd16(v);
        chk("R1 count", v, 0);
        chk("R1 ovf", ovf_o, 0);
        chk("R1 irq", irq_o, 0);

        // Table walk
        foreach (VECS[k]) begin
            start_i = 1'b0;
            mode_i = VECS[k].mode; clk_sel_i = VECS[k].cs;
            wr16(16'd100);
            start_i = 1'b1;
            pulse(VECS[k].mask, int'(VECS[k].n));
            rd16(v);
            n_chk++;
            if (v !== VECS[k].exp) begin
                n_fail++;
                $display("FAIL vector %0d (R3/R6/R9): actual %0h expected %0h", k, v, VECS[k].exp);
            end
        end

        // R2 byte lanes and stopped/running writes
        start_i = 1'b0; mode_i = 2'b00; clk_sel_i = 2'b00;
        wr_byte(1'b0, 8'h34);
        wr_byte(1'b1, 8'h12);
        bus_addr_i = 1'b0; #1;
        chk("R2 low lane", bus_rdata_o, 8'h34);
        bus_addr_i = 1'b1; #1;
        chk("R2 high lane", bus_rdata_o, 8'h12);
        start_i = 1'b1;
        wr16(16'h0005);
        rd16(v);
        chk("R2 running write leaves count", v, 16'h1234);

        // R4 / R11 underflow reload
        start_i = 1'b0;
        wr16(16'd2);
        start_i = 1'b1;
        pulse(4'b0001, 2);
        rd16(v);
        chk("R4 reached zero", v, 0);
        chk("R4 no early ovf", ovf_o, 0);
        @(negedge clk); tick_i = 4'b0001;
        @(negedge clk); tick_i = 4'b0000;
        chk("R4 ovf pulse", ovf_o, 1);
        chk("R11 irq with ovf", irq_o, 1);
        rd16(v);
        chk("R4 reloaded", v, 2);
        @(negedge clk);
        chk("R4 ovf one cycle", ovf_o, 0);

        // R5 hold while stopped
        start_i = 1'b0;
        pulse(4'b1111, 3);
        @(negedge clk); cascade_i = 1'b1;
        @(negedge clk); cascade_i = 1'b0;
        rd16(v);
        chk("R5 hold", v, 2);

        // R6 event counting on pin edges and cascade
        mode_i = 2'b01; clk_sel_i = 2'b00; edge_sel_i = 2'b01;
        wr16(16'd50);
        start_i = 1'b1;
        for (int i = 0; i < 3; i++) begin set_pin(1'b1); set_pin(1'b0); end
        rd16(v);
        chk("R6 rising edges", v, 47);
        edge_sel_i = 2'b00;
        for (int i = 0; i < 3; i++) begin set_pin(1'b1); set_pin(1'b0); end
        rd16(v);
        chk("R6 falling edges", v, 44);
        edge_sel_i = 2'b10;
        for (int i = 0; i < 3; i++) begin set_pin(1'b1); set_pin(1'b0); end
        rd16(v);
        chk("R6 both edges", v, 38);
        clk_sel_i = 2'b10;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); cascade_i = 1'b1;
            @(negedge clk); cascade_i = 1'b0;
        end
        rd16(v);
        chk("R6 cascade pulses", v, 34);
        for (int i = 0; i < 2; i++) begin set_pin(1'b1); set_pin(1'b0); end
        rd16(v);
        chk("R6 pin ignored with cascade source", v, 34);

        // R7 / R8 measurement
        mode_i = 2'b10; clk_sel_i = 2'b00; edge_sel_i = 2'b01;
        set_pin(1'b1);
        set_pin(1'b0);
        pulse(4'b0001, 10);
        @(negedge clk); pin_i = 1'b1;
        irq_seen = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (irq_o) irq_seen++;
        end
        chk("R7 single irq pulse", irq_seen, 1);
        rd16(v);
        chk("R7 period capture", v, 10);
        pulse(4'b0001, 3);
        rd16(v);
        chk("R8 read shows capture", v, 10);
        edge_sel_i = 2'b10;
        set_pin(1'b0);
        rd16(v);
        chk("R7 width capture on fall", v, 3);
        pulse(4'b0001, 7);
        set_pin(1'b1);
        rd16(v);
        chk("R7 width capture on rise", v, 7);

        // R10 wrap in measurement mode
        start_i = 1'b0;
        wr16(16'hFFFE);
        start_i = 1'b1;
        pulse(4'b0001, 1);
        chk("R10 no ovf before wrap", ovf_o, 0);
        @(negedge clk); tick_i = 4'b0001;
        @(negedge clk); tick_i = 4'b0000;
        chk("R10 wrap ovf", ovf_o, 1);
        chk("R10 wrap no irq", irq_o, 0);
        mode_i = 2'b00;
        rd16(v);
        chk("R10 counter wrapped to zero", v, 0);

        finish_run();
    end

endmodule